// File: doc/BRIEF.md
# Dual-Channel Zero-Stuffing Interpolation Filter

The block raises the sample rate of an in-phase/quadrature pair by an integer factor M. A single counter, shared by both channels, produces a one-clock admission strobe every M clocks. On an admission edge each channel's registered stuffing stage loads the current input word. On every other edge it loads zero, so M-1 zero samples follow each real one. Each stuffed stream then passes through its own copy of an identical direct-form FIR low-pass filter. The filter holds full-precision products and sums, and only the output slice is cut down.

The sources hold each input pair stable for at least M clocks. The filtered words come out at the full clock rate, together with a valid flag that rises once the first admitted sample has reached the output.

Top module: `iqint_interp_top`

## Requirements
- R1: Reset is synchronous. After a clock edge with `rst` high, `out_i` and `out_q` read 0 and `out_valid` reads 0.
- R2: Count the clock edges after reset release from 1. Edge k admits the inputs exactly when k ≥ M+1 and (k−M−1) is a multiple of M. This gives one admission every M clocks.
- R3: On every edge that does not admit, both filter inputs are loaded with zero. A finished response is therefore followed by zero outputs.
- R4: Both channels admit on the same edges, and each channel's output depends only on its own input. An impulse on I leaves `out_q` at 0.
- R5: The filter output after edge n is the bit slice [SHIFT+OW−1:SHIFT] of Σ c[k]·s[n−1−k]. Here s[j] is the stuffed word loaded at edge j, and c[k] is the signed coefficient stored at `COEFS[k*W +: W]`. By default c = 5, −3, 20, 41, 33, 9, −2, 1, with SHIFT = 2 and OW = 20.
- R6: With a constant input X, the sum of any M consecutive steady-state outputs equals X·Σc / 2^SHIFT. This holds whenever that value is exact.
- R7: Products and sums keep full width (2W + log2 of TAPS bits). Only the output slice is cut, and it wraps in two's complement, so full-scale inputs give the wrapped slice of the exact sum.
- R8: A sample admitted at edge e contributes c[k]·X to the output after edge e+1+k.
- R9: `out_valid` is low before edge M+2 after reset release and high from edge M+2 onward.
- R10: Input values present at non-admitting edges have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_i | input | W | Signed in-phase sample |
| in_q | input | W | Signed quadrature sample |
| out_i | output | OW | Filtered in-phase output slice |
| out_q | output | OW | Filtered quadrature output slice |
| out_valid | output | 1 | High once the pipeline has filled after reset |

## Verification
An impulse on the I channel only exposes the coefficient order, the one-edge filter latency and the isolation of the Q channel. The run then applies a constant pair of opposite signs, which confirms the interpolation gain over one period of M outputs. Next comes a stream that changes its value on every clock, and the outputs must reflect only the words present at admission edges. Full-scale inputs of both polarities then force the output slice to wrap, which separates full-precision accumulation from early truncation.

// File: rtl/iqint_pkg.sv
package iqint_pkg;

    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int acc_width(input int w, input int taps);
        return 2 * w + safe_clog2(taps);
    endfunction

endpackage

// File: rtl/iqint_stuff_ctrl.sv
module iqint_stuff_ctrl
    import iqint_pkg::*;
#(
    parameter int M = 4
) (
    input  logic clk,
    input  logic rst,
    output logic admit
);
    localparam int CW = safe_clog2(M);
    localparam logic [CW-1:0] CNT_LAST = CW'(M - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ena;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ena = (st_q.cnt == CNT_LAST);
        st_d.cnt = st_d.ena ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign admit = st_q.ena;

    // R2: counter stays in range and the strobe lines up with count zero
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_LAST);
    assert_strobe_phase_R2: assert property (@(posedge clk) disable iff (rst)
        admit |-> (st_q.cnt == '0));

    generate
        if (M > 1) begin : g_spacing
            assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
                admit |=> !admit);
        end
    endgenerate

endmodule

// File: rtl/iqint_fir.sv
module iqint_fir
    import iqint_pkg::*;
#(
    parameter int              W     = 16,
    parameter int              TAPS  = 8,
    parameter logic [TAPS*W-1:0] COEFS = '0,
    parameter int              AW    = acc_width(W, TAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  x,
    output logic [AW-1:0] acc
);
    typedef struct packed {
        logic [TAPS-2:0][W-1:0] dl;
        logic [AW-1:0]          acc;
    } fir_t;

    fir_t st_d, st_q;

    always_comb begin
        logic signed [AW-1:0] sum;
        st_d       = st_q;
        st_d.dl[0] = x;
        for (int k = 1; k < TAPS - 1; k++) begin
            st_d.dl[k] = st_q.dl[k-1];
        end
        sum = AW'($signed(COEFS[0 +: W])) * AW'($signed(x));
        for (int k = 1; k < TAPS; k++) begin
            sum = sum + AW'($signed(COEFS[k*W +: W])) * AW'($signed(st_q.dl[k-1]));
        end
        st_d.acc = sum;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc = st_q.acc;

    // R1: a reset edge leaves the accumulator and delay line at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc == '0 && st_q.dl == '0));

    // R8: the newest tap holds the word presented one edge earlier
    assert_tap_shift_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (st_q.dl[0] == $past(x)));

endmodule

// File: rtl/iqint_interp_top.sv
module iqint_interp_top
    import iqint_pkg::*;
#(
    parameter int                M     = 4,
    parameter int                W     = 16,
    parameter int                TAPS  = 8,
    parameter logic [TAPS*W-1:0] COEFS = {16'sd1, -16'sd2, 16'sd9, 16'sd33,
                                          16'sd41, 16'sd20, -16'sd3, 16'sd5},
    parameter int                OW    = 20,
    parameter int                SHIFT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  in_i,
    input  logic [W-1:0]  in_q,
    output logic [OW-1:0] out_i,
    output logic [OW-1:0] out_q,
    output logic          out_valid
);
    localparam int NCH = 2;
    localparam int AW  = acc_width(W, TAPS);
    localparam int LAT = M + 2;
    localparam int VW  = safe_clog2(LAT + 1);
    localparam logic [VW-1:0] V_FULL = VW'(LAT);

    typedef struct packed {
        logic [NCH-1:0][W-1:0] stuff;
        logic [VW-1:0]         vcnt;
    } top_t;

    top_t st_d, st_q;
    logic admit;
    logic [NCH-1:0][W-1:0]  ch_in;
    logic [NCH-1:0][AW-1:0] acc_w;
    logic [NCH-1:0][OW-1:0] ch_out;

    assign ch_in[0] = in_i;
    assign ch_in[1] = in_q;

    iqint_stuff_ctrl #(.M(M)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .admit (admit)
    );

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            st_d.stuff[c] = admit ? ch_in[c] : '0;
        end
        st_d.vcnt = (st_q.vcnt == V_FULL) ? st_q.vcnt : st_q.vcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [AW-1:0] unused_full;
            iqint_fir #(
                .W     (W),
                .TAPS  (TAPS),
                .COEFS (COEFS),
                .AW    (AW)
            ) u_fir (
                .clk (clk),
                .rst (rst),
                .x   (st_q.stuff[c]),
                .acc (acc_w[c])
            );
            assign unused_full = acc_w[c];
            assign ch_out[c]   = acc_w[c][SHIFT +: OW];
        end
    endgenerate

    assign out_i     = ch_out[0];
    assign out_q     = ch_out[1];
    assign out_valid = (st_q.vcnt == V_FULL);

    // R3: edges without the strobe feed zero to both filters
    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (rst)
        !admit |=> (st_q.stuff == '0));

    // R4: both channels take their own inputs on the same strobe edge
    assert_pair_admit_R4: assert property (@(posedge clk) disable iff (rst)
        admit |=> (st_q.stuff[0] == $past(in_i) && st_q.stuff[1] == $past(in_q)));

    // R9: once valid, it stays valid
    assert_valid_hold_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

endmodule

// File: tb/iqint_interp_top_tb_top.sv
module iqint_interp_top_tb_top;
    localparam int PERIOD = 10;
    localparam int M      = 4;
    localparam int W      = 16;
    localparam int TAPS   = 8;
    localparam int OW     = 20;
    localparam int SHIFT  = 2;
    localparam int COEF [TAPS] = '{5, -3, 20, 41, 33, 9, -2, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] in_i = '0;
    logic [W-1:0] in_q = '0;
    logic [OW-1:0] out_i, out_q;
    logic out_valid;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;
    string tag_i = "R3";
    string tag_q = "R3";

    int     n = 0;
    longint hist_i[$];
    longint hist_q[$];
    longint exp_i = 0, exp_q = 0;
    bit     exp_v = 1'b0;

    iqint_interp_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_i     (out_i),
        .out_q     (out_q),
        .out_valid (out_valid)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic longint slice_out(input longint full);
        longint v;
        v = full >>> SHIFT;
        v = v & ((longint'(1) << OW) - 1);
        if (v[OW-1]) v = v - (longint'(1) << OW);
        return v;
    endfunction

    function automatic longint fir_of(ref longint h[$]);
        longint s = 0;
        for (int k = 0; k < TAPS; k++) begin
            if (k < h.size()) s += COEF[k] * h[k];
        end
        return s;
    endfunction

    task automatic check(input string tag, input longint act, input longint expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at edge %0d", tag, act, expv, n);
        end
    endtask

    // behavioural reference, one step per clock edge
    always @(posedge clk) begin
        if (rst) begin
            n = 0;
            hist_i.delete();
            hist_q.delete();
            exp_i = 0; exp_q = 0; exp_v = 1'b0;
        end else begin
            longint si, sq;
            n++;
            exp_i = slice_out(fir_of(hist_i));
            exp_q = slice_out(fir_of(hist_q));
            if (n >= M + 1 && ((n - M - 1) % M) == 0) begin
                si = longint'($signed(in_i));
                sq = longint'($signed(in_q));
            end else begin
                si = 0; sq = 0;
            end
            hist_i.push_front(si);
            hist_q.push_front(sq);
            if (hist_i.size() > TAPS) begin
                void'(hist_i.pop_back());
                void'(hist_q.pop_back());
            end
            exp_v = (n >= M + 2);
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R9", longint'(out_valid), longint'(exp_v));
            check((exp_i == 0) ? "R3" : tag_i, longint'($signed(out_i)), exp_i);
            check((exp_q == 0) ? "R3" : tag_q, longint'($signed(out_q)), exp_q);
        end
    end

    task automatic wait_admit();
        @(negedge clk);
        while (!((n + 1) >= M + 1 && ((n + 1 - M - 1) % M) == 0)) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        longint sum_i, sum_q;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", longint'(out_i), 0);
        check("R1", longint'(out_q), 0);
        check("R1", longint'(out_valid), 0);
        rst = 1'b0;
        cmp_en = 1'b1;

        // R5 / R8 / R4 / R2: impulse on I only
        tag_i = "R5"; tag_q = "R4";
        wait_admit();
        in_i = W'(4);
        @(negedge clk);
        for (int k = 0; k < TAPS; k++) begin
            @(negedge clk);
            check("R8", longint'($signed(out_i)), COEF[k]);
            check("R4", longint'($signed(out_q)), 0);
            if (k == M - 2) in_i = '0;
        end
        repeat (TAPS + M) @(negedge clk);
        check("R2", longint'($signed(out_i)), 0);

        // R6: constant input gain over one period
        tag_i = "R6"; tag_q = "R6";
        in_i = W'(100);
        in_q = W'(-60);
        repeat (TAPS * M + M) @(negedge clk);
        sum_i = 0; sum_q = 0;
        for (int k = 0; k < M; k++) begin
            @(negedge clk);
            sum_i += longint'($signed(out_i));
            sum_q += longint'($signed(out_q));
        end
        check("R6", sum_i, 100 * 104 / 4);
        check("R6", sum_q, -60 * 104 / 4);

        // R10: values between admission edges must not matter
        tag_i = "R10"; tag_q = "R10";
        for (int j = 0; j < 48; j++) begin
            in_i = W'((j * 1237 + 91) % 4001 - 2000);
            in_q = W'((j * 733 + 17) % 3001 - 1500);
            @(negedge clk);
        end

        // R7: full-scale inputs wrap in the output slice
        tag_i = "R7"; tag_q = "R7";
        in_i = 16'h8000;
        in_q = 16'h7fff;
        repeat (TAPS * M + 8) @(negedge clk);

        // R3: return to silence
        tag_i = "R3"; tag_q = "R3";
        in_i = '0; in_q = '0;
        repeat (TAPS * M + 8) @(negedge clk);
        check("R3", longint'($signed(out_i)), 0);

        finish_run();
    end

endmodule